// File: doc/BRIEF.md
# DMA Ring Command Packet Decoder

This block sits behind the fetch logic of a DMA ring. It accepts a stream of 32-bit command dwords, one per accepted cycle, and splits the stream into packets. Each packet begins with a header dword that selects an operation and carries a count. The decoder then gathers that operation's fixed set of operand dwords and acts on them.

Memory writes and fence writes come out as address/data requests. A trap raises a one-cycle interrupt pulse when interrupts are enabled. A semaphore either signals at once or holds the ring until an external release arrives. Bulk-copy and indirect-buffer packets are only decoded: their length and addresses are reported on a transfer-descriptor output for a separate mover. Unknown operations are skipped and latch a sticky error flag.

Addresses are reported as dword addresses. Each one joins the 8 usable bits of a high operand dword with bits 31:2 of a low operand dword, so the default address width is 38 bits.

Top module: `ring_cmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `err_flag` is 0, and every pulse and status output (`wr_valid`, `irq_pulse`, `pkt_done`, `sem_signal`, `sem_waiting`, `xfer_valid`) is 0.
- R2: Header layout and opcode encodings:
  - Bits 31:28 of a header hold the opcode and bit 22 holds the semaphore mode flag.
  - Bits 15:0 hold the count.
  - Bits 27:23 and 21:16 have no effect on decoding.
  - Opcode encodings: 0x2 write, 0x3 copy, 0x4 indirect buffer, 0x5 semaphore, 0x6 fence, 0x7 trap, 0xF no-op.
- R3: A write packet (0x2) has three parts:
  - It is followed by a low address dword, whose bits 1:0 are ignored, and a high address dword, of which only bits 7:0 are used.
  - After these come `count` data dwords. Each data dword produces one `wr_valid` cycle, in order, at consecutive dword addresses starting at {high[7:0], low[31:2]}.
  - A count of 0 writes nothing.
- R4: A fence packet (0x6) takes a low address dword, a high address dword and a value dword. It produces exactly one write of that value to the joined address.
- R5: A trap packet (0x7) is a single dword. It raises `irq_pulse` for one cycle only if `irq_enable` is 1 in the cycle its header is accepted.
- R6: A semaphore packet (0x5) with mode flag 1 takes a low and a high address dword. It pulses `sem_signal` with `sem_addr` set to the joined address, and it does not stall the stream.
- R7: A semaphore packet with mode flag 0 sets `sem_waiting`, presents the joined address on `sem_addr` and drops `in_ready`. No dword is accepted until `sem_release` is sampled high; the packet then completes and `in_ready` returns to 1.
- R8: A copy packet (0x3) takes four dwords: destination low, source low, destination high, source high. It produces one `xfer_valid` cycle with `xfer_is_ib`=0, `xfer_len` equal to the header count (up to 0xFFFF), and the joined destination and source addresses. No memory write is issued.
- R9: An indirect-buffer packet (0x4) takes an address low dword and a second dword. The second dword holds the length in bits 31:16 and the address high in bits 7:0. The packet produces one `xfer_valid` cycle with `xfer_is_ib`=1, `xfer_len` equal to that length, and `xfer_src` equal to the 32-byte-aligned dword address (low address bits 4:0 forced to zero). `xfer_dst` is 0.
- R10: A no-op (0xF) consumes only its header. Any other opcode not listed in R2, constant fill (0xD) included, also consumes one dword and sets `err_flag`, which stays set until reset.
- R11: `pkt_done` is high for one cycle, with `pkt_op` holding the packet's opcode, in the cycle after the packet's last dword is accepted. For a waiting semaphore, that cycle is the one after the release is sampled. Write, interrupt, signal and transfer outputs of a packet appear in that same cycle after their triggering dword.
- R12: Cycles with `in_valid` low between any two dwords of a packet change nothing; decoding resumes with the next accepted dword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enable | input | 1 | Allows trap packets to raise an interrupt |
| in_valid | input | 1 | A command dword is offered |
| in_data | input | 32 | Command dword |
| in_ready | output | 1 | Dword is accepted when this and `in_valid` are high |
| sem_release | input | 1 | Releases a waiting semaphore |
| wr_valid | output | 1 | Memory write request, one cycle |
| wr_addr | output | 30+ADDR_HI_W (38) | Dword address of the write |
| wr_data | output | 32 | Write data |
| irq_pulse | output | 1 | Interrupt pulse from a trap packet |
| pkt_done | output | 1 | A packet has completed |
| pkt_op | output | 4 | Opcode of the completed packet |
| sem_signal | output | 1 | Semaphore signal pulse |
| sem_waiting | output | 1 | The decoder holds on a semaphore wait |
| sem_addr | output | 30+ADDR_HI_W (38) | Semaphore dword address |
| xfer_valid | output | 1 | Copy or indirect-buffer descriptor is valid |
| xfer_is_ib | output | 1 | 1 for indirect buffer, 0 for copy |
| xfer_len | output | 16 | Transfer length in dwords |
| xfer_dst | output | 30+ADDR_HI_W (38) | Copy destination dword address |
| xfer_src | output | 30+ADDR_HI_W (38) | Copy source or indirect-buffer dword address |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench targets four corner cases, each tied to a specific failure:
- A write with a zero count. A decoder that enters its data phase anyway would swallow the next header as data.
- A copy with the maximum count. Getting it wrong shows up as a truncated length or an operand-order swap between destination and source.
- A header with the ignored bits set. Decoding them would change the operand count or the semaphore mode.
- A dword already offered while a semaphore wait is in force. It must not be taken before the release.

It also checks that unknown opcodes, constant fill among them, latch the error flag permanently and cost one dword each. Random packet mixes with idle gaps show whether an operand index or remaining-count register advances without an accepted dword.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int OPC_W     = 4;
    localparam int OPC_LSB   = 28;
    localparam int SFLAG_BIT = 22;
    localparam int LEN_LSB   = 16;
    localparam int DW_SHIFT  = 2;
    localparam int IB_ZERO   = 3;   // dword-address bits cleared for 32-byte alignment

    localparam logic [OPC_W-1:0] OPC_WRITE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_COPY  = 4'h3;
    localparam logic [OPC_W-1:0] OPC_IBUF  = 4'h4;
    localparam logic [OPC_W-1:0] OPC_SEM   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_FENCE = 4'h6;
    localparam logic [OPC_W-1:0] OPC_TRAP  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_NOP   = 4'hF;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_OPND = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;

    function automatic logic [2:0] operand_count(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_WRITE: return 3'd2;
            OPC_COPY:  return 3'd4;
            OPC_IBUF:  return 3'd2;
            OPC_SEM:   return 3'd2;
            OPC_FENCE: return 3'd3;
            default:   return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/rcd_hdr_decode.sv
`timescale 1ns/1ps
module rcd_hdr_decode
    import rcd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic              sflag,
    output logic [CNT_W-1:0]  cnt,
    output logic [2:0]        n_opnd,
    output logic              known
);
    logic unused_hdr_bits;

    assign opc    = word[OPC_LSB +: OPC_W];
    assign sflag  = word[SFLAG_BIT];
    assign cnt    = word[CNT_W-1:0];
    assign n_opnd = operand_count(opc);

    always_comb begin
        case (opc)
            OPC_WRITE, OPC_COPY, OPC_IBUF, OPC_SEM,
            OPC_FENCE, OPC_TRAP, OPC_NOP: known = 1'b1;
            default:                      known = 1'b0;
        endcase
    end

    assign unused_hdr_bits = ^{word[OPC_LSB-1:SFLAG_BIT+1], word[SFLAG_BIT-1:CNT_W]};
endmodule

// File: rtl/rcd_addr_join.sv
`timescale 1ns/1ps
module rcd_addr_join
    import rcd_pkg::*;
#(
    parameter int HI_W     = 8,
    parameter int ZERO_LSB = 0,
    localparam int AW      = WORD_W - DW_SHIFT + HI_W
) (
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    output logic [AW-1:0]     daddr
);
    logic unused_join_bits;

    generate
        if (ZERO_LSB == 0) begin : g_plain
            assign daddr = {hi[HI_W-1:0], lo[WORD_W-1:DW_SHIFT]};
            assign unused_join_bits = ^{lo[DW_SHIFT-1:0], hi[WORD_W-1:HI_W]};
        end else begin : g_aligned
            assign daddr = {hi[HI_W-1:0], lo[WORD_W-1:DW_SHIFT+ZERO_LSB], {ZERO_LSB{1'b0}}};
            assign unused_join_bits = ^{lo[DW_SHIFT+ZERO_LSB-1:0], hi[WORD_W-1:HI_W]};
        end
    endgenerate
endmodule

// File: rtl/ring_cmd_decoder.sv
`timescale 1ns/1ps
module ring_cmd_decoder
    import rcd_pkg::*;
#(
    parameter int ADDR_HI_W = 8,
    localparam int AW       = WORD_W - DW_SHIFT + ADDR_HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_enable,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              sem_release,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              irq_pulse,
    output logic              pkt_done,
    output logic [OPC_W-1:0]  pkt_op,
    output logic              sem_signal,
    output logic              sem_waiting,
    output logic [AW-1:0]     sem_addr,
    output logic              xfer_valid,
    output logic              xfer_is_ib,
    output logic [CNT_W-1:0]  xfer_len,
    output logic [AW-1:0]     xfer_dst,
    output logic [AW-1:0]     xfer_src,
    output logic              err_flag
);
    localparam int N_JOIN              = 4;
    localparam logic [CNT_W-1:0] CNT_1 = CNT_W'(1);
    localparam logic [AW-1:0]    AW_1  = AW'(1);

    typedef struct packed {
        seq_state_e          st;
        logic [OPC_W-1:0]    op;
        logic                sflag;
        logic [2:0]          nops;
        logic [1:0]          idx;
        logic [CNT_W-1:0]    left;
        logic [WORD_W-1:0]   op0;
        logic [WORD_W-1:0]   op1;
        logic [WORD_W-1:0]   op2;
        logic [AW-1:0]       wa;
        logic                wr_v;
        logic [AW-1:0]       wr_a;
        logic [WORD_W-1:0]   wr_d;
        logic                irq;
        logic                done;
        logic [OPC_W-1:0]    done_op;
        logic                sem_sig;
        logic [AW-1:0]       sem_a;
        logic                xv;
        logic                xib;
        logic [CNT_W-1:0]    xlen;
        logic [AW-1:0]       xdst;
        logic [AW-1:0]       xsrc;
        logic                err;
    } dec_state_t;

    dec_state_t q, d;

    // header field decode of the offered dword
    logic [OPC_W-1:0] hd_op;
    logic             hd_s;
    logic [CNT_W-1:0] hd_cnt;
    logic [2:0]       hd_nops;
    logic             hd_known;

    rcd_hdr_decode u_hdr (
        .word   (in_data),
        .opc    (hd_op),
        .sflag  (hd_s),
        .cnt    (hd_cnt),
        .n_opnd (hd_nops),
        .known  (hd_known)
    );

    // address joins: 0 = op0/current, 1 = op0/op1, 2 = op0/op2, 3 = op1/current
    logic [WORD_W-1:0] j_lo [N_JOIN];
    logic [WORD_W-1:0] j_hi [N_JOIN];
    logic [AW-1:0]     j_addr [N_JOIN];
    logic [AW-1:0]     ib_addr;

    assign j_lo[0] = q.op0;  assign j_hi[0] = in_data;
    assign j_lo[1] = q.op0;  assign j_hi[1] = q.op1;
    assign j_lo[2] = q.op0;  assign j_hi[2] = q.op2;
    assign j_lo[3] = q.op1;  assign j_hi[3] = in_data;

    generate
        for (genvar gi = 0; gi < N_JOIN; gi++) begin : g_join
            rcd_addr_join #(.HI_W(ADDR_HI_W), .ZERO_LSB(0)) u_join (
                .lo    (j_lo[gi]),
                .hi    (j_hi[gi]),
                .daddr (j_addr[gi])
            );
        end
    endgenerate

    rcd_addr_join #(.HI_W(ADDR_HI_W), .ZERO_LSB(IB_ZERO)) u_join_ib (
        .lo    (q.op0),
        .hi    (in_data),
        .daddr (ib_addr)
    );

    logic take;
    logic opnd_last;

    assign in_ready  = (q.st != ST_HOLD);
    assign take      = in_valid && in_ready;
    assign opnd_last = ({1'b0, q.idx} == (q.nops - 3'd1));

    always_comb begin
        d         = q;
        d.wr_v    = 1'b0;
        d.irq     = 1'b0;
        d.done    = 1'b0;
        d.sem_sig = 1'b0;
        d.xv      = 1'b0;

        case (q.st)
            ST_HDR: begin
                if (take) begin
                    d.op    = hd_op;
                    d.sflag = hd_s;
                    d.left  = hd_cnt;
                    d.nops  = hd_nops;
                    d.idx   = 2'd0;
                    if (hd_nops == 3'd0) begin
                        d.done    = 1'b1;
                        d.done_op = hd_op;
                        if (hd_op == OPC_TRAP && irq_enable) d.irq = 1'b1;
                        if (!hd_known) d.err = 1'b1;
                    end else begin
                        d.st = ST_OPND;
                    end
                end
            end

            ST_OPND: begin
                if (take) begin
                    case (q.idx)
                        2'd0:    d.op0 = in_data;
                        2'd1:    d.op1 = in_data;
                        default: d.op2 = in_data;
                    endcase
                    if (!opnd_last) begin
                        d.idx = q.idx + 2'd1;
                    end else begin
                        d.st      = ST_HDR;
                        d.done    = 1'b1;
                        d.done_op = q.op;
                        case (q.op)
                            OPC_WRITE: begin
                                if (q.left != '0) begin
                                    d.st   = ST_DATA;
                                    d.done = 1'b0;
                                    d.wa   = j_addr[0];
                                end
                            end
                            OPC_FENCE: begin
                                d.wr_v = 1'b1;
                                d.wr_a = j_addr[1];
                                d.wr_d = in_data;
                            end
                            OPC_SEM: begin
                                d.sem_a = j_addr[0];
                                if (q.sflag) begin
                                    d.sem_sig = 1'b1;
                                end else begin
                                    d.st   = ST_HOLD;
                                    d.done = 1'b0;
                                end
                            end
                            OPC_COPY: begin
                                d.xv   = 1'b1;
                                d.xib  = 1'b0;
                                d.xlen = q.left;
                                d.xdst = j_addr[2];
                                d.xsrc = j_addr[3];
                            end
                            OPC_IBUF: begin
                                d.xv   = 1'b1;
                                d.xib  = 1'b1;
                                d.xlen = in_data[LEN_LSB +: CNT_W];
                                d.xdst = '0;
                                d.xsrc = ib_addr;
                            end
                            default: ;
                        endcase
                    end
                end
            end

            ST_DATA: begin
                if (take) begin
                    d.wr_v = 1'b1;
                    d.wr_a = q.wa;
                    d.wr_d = in_data;
                    d.wa   = q.wa + AW_1;
                    d.left = q.left - CNT_1;
                    if (q.left == CNT_1) begin
                        d.st      = ST_HDR;
                        d.done    = 1'b1;
                        d.done_op = q.op;
                    end
                end
            end

            ST_HOLD: begin
                if (sem_release) begin
                    d.st      = ST_HDR;
                    d.done    = 1'b1;
                    d.done_op = q.op;
                end
            end

            default: d.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_valid    = q.wr_v;
    assign wr_addr     = q.wr_a;
    assign wr_data     = q.wr_d;
    assign irq_pulse   = q.irq;
    assign pkt_done    = q.done;
    assign pkt_op      = q.done_op;
    assign sem_signal  = q.sem_sig;
    assign sem_waiting = (q.st == ST_HOLD);
    assign sem_addr    = q.sem_a;
    assign xfer_valid  = q.xv;
    assign xfer_is_ib  = q.xib;
    assign xfer_len    = q.xlen;
    assign xfer_dst    = q.xdst;
    assign xfer_src    = q.xsrc;
    assign err_flag    = q.err;
endmodule

// File: rtl/rcd_checker.sv
`timescale 1ns/1ps
module rcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_enable,
    input logic       in_ready,
    input logic       sem_waiting,
    input logic       sem_release,
    input logic       irq_pulse,
    input logic       pkt_done,
    input logic [3:0] pkt_op,
    input logic       xfer_valid,
    input logic       err_flag
);
    // R5: an interrupt needs the enable in the accepting cycle
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(irq_enable));

    // R11: an interrupt comes with completion of a trap packet
    p_irq_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (pkt_done && pkt_op == 4'h7));

    // R7: nothing is accepted while a semaphore wait holds
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sem_waiting |-> !in_ready);

    // R7: the wait ends only on a release
    p_hold_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_waiting && !sem_release) |=> sem_waiting);

    // R10: the error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R8: a transfer descriptor marks packet completion
    p_xfer_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> pkt_done);
endmodule

bind ring_cmd_decoder rcd_checker u_rcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_enable  (irq_enable),
    .in_ready    (in_ready),
    .sem_waiting (sem_waiting),
    .sem_release (sem_release),
    .irq_pulse   (irq_pulse),
    .pkt_done    (pkt_done),
    .pkt_op      (pkt_op),
    .xfer_valid  (xfer_valid),
    .err_flag    (err_flag)
);

// File: tb/ring_cmd_decoder_bench.sv
`timescale 1ns/1ps
module ring_cmd_decoder_bench;
    localparam int HI_W = 8;
    localparam int AW   = 30 + HI_W;
    localparam int XW   = 1 + 16 + 2 * AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_enable = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic sem_release = 1'b0;
    logic in_ready, wr_valid, irq_pulse, pkt_done, sem_signal, sem_waiting;
    logic xfer_valid, xfer_is_ib, err_flag;
    logic [AW-1:0] wr_addr, sem_addr, xfer_dst, xfer_src;
    logic [31:0] wr_data;
    logic [3:0] pkt_op;
    logic [15:0] xfer_len;

    always #2.5 clk = ~clk;

    ring_cmd_decoder #(.ADDR_HI_W(HI_W)) u_ring_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .sem_release(sem_release), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_pulse(irq_pulse), .pkt_done(pkt_done),
        .pkt_op(pkt_op), .sem_signal(sem_signal), .sem_waiting(sem_waiting),
        .sem_addr(sem_addr), .xfer_valid(xfer_valid), .xfer_is_ib(xfer_is_ib),
        .xfer_len(xfer_len), .xfer_dst(xfer_dst), .xfer_src(xfer_src),
        .err_flag(err_flag)
    );

    int total = 0;
    int bad = 0;
    bit use_gaps = 1'b0;
    bit finished = 1'b0;

    logic [AW+31:0] obs_wr[$], exp_wr[$];
    logic [3:0]     obs_op[$], exp_op[$];
    logic [XW-1:0]  obs_xf[$], exp_xf[$];
    logic [AW-1:0]  obs_sem[$], exp_sem[$];
    int obs_irq = 0;
    int exp_irq = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid)   obs_wr.push_back({wr_addr, wr_data});
            if (pkt_done)   obs_op.push_back(pkt_op);
            if (xfer_valid) obs_xf.push_back({xfer_is_ib, xfer_len, xfer_dst, xfer_src});
            if (sem_signal) obs_sem.push_back(sem_addr);
            if (irq_pulse)  obs_irq++;
        end
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(logic [3:0] op, logic s, logic [15:0] n);
        return {op, 4'h0, 1'b0, s, 6'h00, n};
    endfunction

    function automatic logic [AW-1:0] dwa(logic [31:0] lo, logic [31:0] hi);
        return {hi[HI_W-1:0], lo[31:2]};
    endfunction

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic push(logic [31:0] w);
        if (use_gaps) idle(int'($urandom % 3));
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare_all(string req);
        idle(3);
        check({req, " write count"}, 128'(obs_wr.size()), 128'(exp_wr.size()));
        for (int i = 0; i < exp_wr.size() && i < obs_wr.size(); i++)
            check({req, " write"}, 128'(obs_wr[i]), 128'(exp_wr[i]));
        check({req, " done count"}, 128'(obs_op.size()), 128'(exp_op.size()));
        for (int i = 0; i < exp_op.size() && i < obs_op.size(); i++)
            check({req, " R11 done op"}, 128'(obs_op[i]), 128'(exp_op[i]));
        check({req, " xfer count"}, 128'(obs_xf.size()), 128'(exp_xf.size()));
        for (int i = 0; i < exp_xf.size() && i < obs_xf.size(); i++)
            check({req, " xfer"}, 128'(obs_xf[i]), 128'(exp_xf[i]));
        check({req, " signal count"}, 128'(obs_sem.size()), 128'(exp_sem.size()));
        for (int i = 0; i < exp_sem.size() && i < obs_sem.size(); i++)
            check({req, " signal addr"}, 128'(obs_sem[i]), 128'(exp_sem[i]));
        check({req, " irq count"}, 128'(obs_irq), 128'(exp_irq));
        obs_wr.delete(); exp_wr.delete(); obs_op.delete(); exp_op.delete();
        obs_xf.delete(); exp_xf.delete(); obs_sem.delete(); exp_sem.delete();
        obs_irq = 0; exp_irq = 0;
    endtask

    task automatic send_write(logic [31:0] h, logic [31:0] lo, logic [31:0] hi);
        push(h); push(lo); push(hi);
        for (int i = 0; i < int'(h[15:0]); i++) begin
            logic [31:0] dv;
            dv = $urandom;
            push(dv);
            exp_wr.push_back({dwa(lo, hi) + AW'(i), dv});
        end
        exp_op.push_back(4'h2);
    endtask

    task automatic send_fence(logic [31:0] lo, logic [31:0] hi, logic [31:0] v);
        push(hdr(4'h6, 1'b0, 16'h0)); push(lo); push(hi); push(v);
        exp_wr.push_back({dwa(lo, hi), v});
        exp_op.push_back(4'h6);
    endtask

    task automatic send_trap(logic en);
        irq_enable = en;
        push(hdr(4'h7, 1'b0, 16'h0));
        if (en) exp_irq++;
        exp_op.push_back(4'h7);
    endtask

    task automatic send_copy(logic [15:0] n, logic [31:0] dl, logic [31:0] sl,
                             logic [31:0] dh, logic [31:0] sh);
        push(hdr(4'h3, 1'b0, n)); push(dl); push(sl); push(dh); push(sh);
        exp_xf.push_back({1'b0, n, dwa(dl, dh), dwa(sl, sh)});
        exp_op.push_back(4'h3);
    endtask

    task automatic send_ib(logic [31:0] lo, logic [31:0] w1);
        push(hdr(4'h4, 1'b0, 16'h0)); push(lo); push(w1);
        exp_xf.push_back({1'b1, w1[31:16], AW'(0), {w1[7:0], lo[31:5], 3'b000}});
        exp_op.push_back(4'h4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 in_ready", 128'(in_ready), 128'(1));
        check("R1 outputs", 128'({wr_valid, irq_pulse, pkt_done, sem_signal,
                                  sem_waiting, xfer_valid, err_flag}), 128'(0));

        // R3 + R11: write with three data dwords, low address bits ignored
        push(hdr(4'h2, 1'b0, 16'd3)); push(32'h1234_5677); push(32'hFFFF_FFA5);
        for (int i = 0; i < 3; i++) begin
            logic [31:0] dv;
            dv = 32'hC0DE_0000 + 32'(i);
            push(dv);
            check("R11 write same cycle", 128'(wr_valid), 128'(1));
            exp_wr.push_back({dwa(32'h1234_5677, 32'hFFFF_FFA5) + AW'(i), dv});
        end
        check("R11 done after last data", 128'({pkt_done, pkt_op}), 128'({1'b1, 4'h2}));
        exp_op.push_back(4'h2);
        compare_all("R3 write n=3");

        // R3: zero count writes nothing, next header decoded normally
        send_write(hdr(4'h2, 1'b0, 16'd0), 32'h0000_1000, 32'h0000_0001);
        push(hdr(4'hF, 1'b0, 16'h0));
        exp_op.push_back(4'hF);
        compare_all("R3 write n=0");

        // R2: ignored header bits and t bit set
        send_write(32'h2FBF_0002, 32'h0000_2000, 32'h0000_0002);
        compare_all("R2 header noise");

        // R4: fence
        send_fence(32'h8765_4320, 32'h0000_0077, 32'h0000_ABCD);
        compare_all("R4 fence");

        // R5: trap gated by enable
        send_trap(1'b0);
        check("R5 trap disabled", 128'(irq_pulse), 128'(0));
        send_trap(1'b1);
        check("R5 trap enabled", 128'(irq_pulse), 128'(1));
        compare_all("R5 trap");

        // R6: semaphore signal
        push(hdr(4'h5, 1'b1, 16'h0)); push(32'h0000_4444); push(32'h0000_0009);
        exp_sem.push_back(dwa(32'h0000_4444, 32'h0000_0009));
        exp_op.push_back(4'h5);
        check("R6 no stall", 128'(in_ready), 128'(1));
        compare_all("R6 signal");

        // R7: semaphore wait holds a pending dword until release
        push(hdr(4'h5, 1'b0, 16'h0)); push(32'h0000_5550); push(32'h0000_0003);
        check("R7 waiting", 128'({sem_waiting, in_ready}), 128'({1'b1, 1'b0}));
        check("R7 wait addr", 128'(sem_addr), 128'(dwa(32'h0000_5550, 32'h0000_0003)));
        in_valid = 1'b1;
        in_data  = hdr(4'hF, 1'b0, 16'h0);
        idle(3);
        check("R7 still held", 128'({sem_waiting, in_ready, pkt_done}), 128'({1'b1, 1'b0, 1'b0}));
        sem_release = 1'b1;
        @(negedge clk);
        sem_release = 1'b0;
        check("R7 released", 128'({pkt_done, pkt_op, in_ready}), 128'({1'b1, 4'h5, 1'b1}));
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 pending taken after", 128'({pkt_done, pkt_op}), 128'({1'b1, 4'hF}));
        exp_op.push_back(4'h5);
        exp_op.push_back(4'hF);
        compare_all("R7 wait");

        // R8: copy with maximum count
        send_copy(16'hFFFF, 32'hAAAA_0004, 32'hBBBB_0008, 32'h0000_0011, 32'h0000_0022);
        compare_all("R8 copy");

        // R9: indirect buffer, low address bits masked
        send_ib(32'h1234_567F, 32'h0040_3355);
        compare_all("R9 indirect");

        // R10: unknown opcodes and constant fill, error sticky
        push(hdr(4'hF, 1'b0, 16'h5));
        check("R10 nop no error", 128'(err_flag), 128'(0));
        push(hdr(4'hD, 1'b0, 16'h2));
        check("R10 fill sets error", 128'(err_flag), 128'(1));
        push(hdr(4'h0, 1'b0, 16'h0));
        push(hdr(4'hF, 1'b0, 16'h0));
        check("R10 error sticky", 128'(err_flag), 128'(1));
        exp_op.push_back(4'hF); exp_op.push_back(4'hD);
        exp_op.push_back(4'h0); exp_op.push_back(4'hF);
        compare_all("R10 unknown");

        // R12 with R3 R4 R5 R8: random mix with idle gaps
        use_gaps = 1'b1;
        for (int p = 0; p < 60; p++) begin
            case ($urandom % 5)
                0: send_write(hdr(4'h2, 1'b0, 16'($urandom % 6)), $urandom, $urandom);
                1: send_fence($urandom, $urandom, $urandom);
                2: begin push(hdr(4'hF, 1'b0, 16'($urandom))); exp_op.push_back(4'hF); end
                3: send_trap(1'($urandom % 2));
                default: send_copy(16'($urandom), $urandom, $urandom, $urandom, $urandom);
            endcase
        end
        use_gaps = 1'b0;
        compare_all("R12 random");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule